// File: doc/BRIEF.md
# Stable-Storage Block Mover

This block copies a run of 16-bit words between a word-addressed memory and a slow stable-storage device. The device sits behind two plain 16-bit registers: a general output register the block writes, and a general input register it reads. The top bits of each output word carry the device control: bit 15 selects reading from the device, bit 14 is the device clock and bit 12 keeps the device powered.

A transfer is launched with a start pulse together with a base address, a word count and a direction. When reading from the device, each word costs a clock-high write, a clock-low write, a fixed settling wait and a sample of the input register, and is then stored to memory. When writing to the device, each word is fetched from memory and written twice: once with bit 14 forced high, then with bit 14 forced low. Words move in groups of up to 16. The first group is sized so that the rest of the block is a whole number of full groups. Between groups a pending interrupt halts the transfer; the pointer and remaining-count outputs then hold exactly the values needed to restart it.

Top module: `sbx_top`

## Requirements
- R1: After reset, and whenever no transfer is in progress, busy_o, done_o, gen_out_we_o and mem_req_o are low; ptr_o and remain_o reset to 0.
- R2: A start with count 0 pulses done_o with no device write and no memory access, suspended_o low and remain_o 0.
- R3: In read-from-device mode (dir_in_i=1) each word begins with a write of 16'hD000 (bit 15, bit 14 and bit 12 set), followed in the very next cycle by a write of 16'h9000 (bit 14 cleared).
- R4: The input register is sampled no earlier than SETTLE clock edges after the edge that writes the clock-low word. The sampled word is stored to memory at base+i for word i.
- R5: In write-to-device mode (dir_in_i=0) word i is read from memory at base+i. It is then written as data with bit 14 set, and in the next cycle as data with bit 14 cleared.
- R6: The first group holds ((count-1) mod 16)+1 words and every later group holds 16. Interrupts are checked only before groups after the first, so a transfer finishing within its first group is never suspended.
- R7: If irq_pending_i is high at a group boundary with words left, the transfer stops. done_o pulses with suspended_o high, ptr_o = base + words moved and remain_o = words left.
- R8: Restarting with base=ptr_o and count=remain_o after a suspend moves exactly the remaining words, continuing at the next address.
- R9: done_o is high for exactly one cycle per transfer.
- R10: A start pulse while busy_o is high is ignored: the running transfer keeps its direction, address and count.
- R11: ptr_o advances by one and remain_o drops by one per word moved; a completed transfer ends with remain_o 0 and ptr_o = base + count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted when idle |
| dir_in_i | input | 1 | 1: device to memory, 0: memory to device |
| base_i | input | ADDR_W | First memory word address |
| count_i | input | CNT_W | Number of words |
| irq_pending_i | input | 1 | Interrupt pending, checked between groups |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| suspended_o | output | 1 | Last transfer stopped for an interrupt |
| ptr_o | output | ADDR_W | Next memory address |
| remain_o | output | CNT_W | Words not yet moved |
| mem_req_o | output | 1 | Memory request, held until ack |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| gen_out_o | output | 16 | General output register value |
| gen_out_we_o | output | 1 | General output register write strobe |
| gen_in_i | input | 16 | General input register |

## Verification
A sampling state that leaves its settle wait early stores a placeholder word instead of device data. This shows up at the memory write of that same word, a few cycles after the clock-low write. A wrong group-size or group-count state shows up only at the next group boundary: a suspend arrives after the wrong number of words, with ptr_o and remain_o wrong. A clock-bit sequencing error shows up immediately on gen_out_o, as two consecutive writes that are not the required high-then-low pair.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam logic [15:0] CTL_DIR_IN = 16'h8000;
  localparam logic [15:0] CTL_CLK    = 16'h4000;
  localparam logic [15:0] CTL_PWR    = 16'h1000;
  localparam int          CLK_BIT    = 14;

  typedef enum logic [2:0] {
    T_IDLE, T_GRP, T_ISSUE, T_WAIT, T_DONE
  } top_st_e;

  typedef enum logic [2:0] {
    W_IDLE, W_CLK_HI, W_CLK_LO, W_SETTLE, W_STORE, W_LOAD, W_OUT_HI, W_OUT_LO
  } word_st_e;
endpackage

// File: rtl/sbx_group_ctl.sv
module sbx_group_ctl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int GROUP  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              grp_load_i,
  input  logic              word_done_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              rem_zero_o,
  output logic              grp_last_o,
  output logic              first_grp_o
);
  localparam int GRP_W = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam int GL_W  = GRP_W + 1;

  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  rem_q, rem_m1;
  logic [GL_W-1:0]   left_q, grp_size;
  logic              first_q;

  // first group takes the remainder so later groups are full
  assign rem_m1   = rem_q - 1'b1;
  assign grp_size = GL_W'(rem_m1 & CNT_W'(GROUP - 1)) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      ptr_q   <= base_i;
      rem_q   <= count_i;
      left_q  <= '0;
      first_q <= 1'b1;
    end else if (grp_load_i) begin
      left_q  <= grp_size;
      first_q <= 1'b0;
    end else if (word_done_i) begin
      ptr_q  <= ptr_q + 1'b1;
      rem_q  <= rem_m1;
      left_q <= left_q - 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign remain_o    = rem_q;
  assign rem_zero_o  = (rem_q == '0);
  assign grp_last_o  = (left_q == GL_W'(1));
  assign first_grp_o = first_q;

  p_grp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= GL_W'(GROUP));

  p_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && !load_i && !grp_load_i) |=>
      (remain_o == $past(remain_o) - 1'b1) && (ptr_o == $past(ptr_o) + 1'b1));
endmodule

// File: rtl/sbx_word_seq.sv
module sbx_word_seq
  import sbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETTLE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              dir_in_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       gen_in_i,
  output logic [15:0]       gen_out_o,
  output logic              gen_out_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              word_done_o
);
  localparam int SC_W = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1;

  word_st_e        st_q, st_d;
  logic [SC_W-1:0] cnt_q;
  logic [15:0]     data_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      W_IDLE:   if (go_i) st_d = dir_in_i ? W_CLK_HI : W_LOAD;
      W_CLK_HI: st_d = W_CLK_LO;
      W_CLK_LO: st_d = W_SETTLE;
      W_SETTLE: if (cnt_q == SC_W'(SETTLE - 1)) st_d = W_STORE;
      W_STORE:  if (mem_ack_i) st_d = W_IDLE;
      W_LOAD:   if (mem_ack_i) st_d = W_OUT_HI;
      W_OUT_HI: st_d = W_OUT_LO;
      W_OUT_LO: st_d = W_IDLE;
      default:  st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == W_CLK_LO) cnt_q <= '0;
      else if (st_q == W_SETTLE) cnt_q <= cnt_q + 1'b1;
      if (st_q == W_SETTLE && st_d == W_STORE) data_q <= gen_in_i;
      if (st_q == W_LOAD && mem_ack_i) data_q <= mem_rdata_i;
    end
  end

  always_comb begin
    gen_out_o    = '0;
    gen_out_we_o = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    word_done_o  = 1'b0;
    unique case (st_q)
      W_CLK_HI: begin gen_out_we_o = 1'b1; gen_out_o = CTL_DIR_IN | CTL_PWR | CTL_CLK; end
      W_CLK_LO: begin gen_out_we_o = 1'b1; gen_out_o = CTL_DIR_IN | CTL_PWR; end
      W_STORE:  begin mem_req_o = 1'b1; mem_we_o = 1'b1; word_done_o = mem_ack_i; end
      W_LOAD:   mem_req_o = 1'b1;
      W_OUT_HI: begin gen_out_we_o = 1'b1; gen_out_o = data_q | CTL_CLK; end
      W_OUT_LO: begin gen_out_we_o = 1'b1; gen_out_o = data_q & ~CTL_CLK; word_done_o = 1'b1; end
      default: ;
    endcase
  end

  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = data_q;

  p_clk_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_out_we_o && gen_out_o[CLK_BIT]) |=> (gen_out_we_o && !gen_out_o[CLK_BIT]));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/sbx_top.sv
module sbx_top
  import sbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int GROUP  = 16,
  parameter int SETTLE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_in_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              irq_pending_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              suspended_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [15:0]       gen_out_o,
  output logic              gen_out_we_o,
  input  logic [15:0]       gen_in_i
);
  localparam int SF_W = $clog2(SETTLE + 1) + 1;

  top_st_e st_q, st_d;
  logic    dir_q, susp_q, susp_set, susp_clr;
  logic    load, grp_load, go, word_done;
  logic    rem_zero, grp_last, first_grp;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    grp_load = 1'b0;
    go       = 1'b0;
    susp_set = 1'b0;
    susp_clr = 1'b0;
    unique case (st_q)
      T_IDLE: if (start_i) begin load = 1'b1; susp_clr = 1'b1; st_d = T_GRP; end
      T_GRP: begin
        if (rem_zero) st_d = T_DONE;
        else if (!first_grp && irq_pending_i) begin susp_set = 1'b1; st_d = T_DONE; end
        else begin grp_load = 1'b1; st_d = T_ISSUE; end
      end
      T_ISSUE: begin go = 1'b1; st_d = T_WAIT; end
      T_WAIT:  if (word_done) st_d = grp_last ? T_GRP : T_ISSUE;
      T_DONE:  st_d = T_IDLE;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= T_IDLE;
      dir_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) dir_q <= dir_in_i;
      if (susp_clr) susp_q <= 1'b0;
      else if (susp_set) susp_q <= 1'b1;
    end
  end

  assign busy_o      = (st_q != T_IDLE);
  assign done_o      = (st_q == T_DONE);
  assign suspended_o = susp_q;

  sbx_group_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .GROUP(GROUP)) u_grp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .base_i(base_i), .count_i(count_i),
    .grp_load_i(grp_load), .word_done_i(word_done), .ptr_o(ptr_o), .remain_o(remain_o),
    .rem_zero_o(rem_zero), .grp_last_o(grp_last), .first_grp_o(first_grp)
  );

  sbx_word_seq #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .dir_in_i(dir_q), .addr_i(ptr_o),
    .gen_in_i(gen_in_i), .gen_out_o(gen_out_o), .gen_out_we_o(gen_out_we_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .word_done_o(word_done)
  );

  // cycles since the last clock-low write in read mode, saturating
  logic [SF_W-1:0] since_fall_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_fall_q <= '0;
    else if (gen_out_we_o && gen_out_o[15] && !gen_out_o[CLK_BIT]) since_fall_q <= '0;
    else if (since_fall_q < SF_W'(SETTLE)) since_fall_q <= since_fall_q + 1'b1;
  end

  p_settle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (since_fall_q >= SF_W'(SETTLE)));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!gen_out_we_o && !mem_req_o && !done_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_zero_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_GRP && rem_zero) |=> (done_o && !suspended_o));
endmodule

// File: tb/sbx_top_test.sv
`timescale 1ns/1ps
module sbx_top_test;
  localparam int SETTLE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir_in = 1'b0, irq = 1'b0;
  logic [15:0] base = '0, count = '0;
  logic        busy, done, susp;
  logic [15:0] ptr, remain;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [15:0] gen_out, gen_in;
  logic        gen_we;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sbx_top #(.SETTLE(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_in_i(dir_in), .base_i(base),
    .count_i(count), .irq_pending_i(irq), .busy_o(busy), .done_o(done),
    .suspended_o(susp), .ptr_o(ptr), .remain_o(remain), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .gen_out_o(gen_out),
    .gen_out_we_o(gen_we), .gen_in_i(gen_in)
  );

  function automatic logic [15:0] rd_word(input logic [15:0] a);
    return 16'hC300 ^ (a * 16'h0025);
  endfunction
  function automatic logic [15:0] dev_word(input int i);
    return 16'h5A00 ^ 16'(i * 13);
  endfunction

  // device and memory models, all state written here only
  logic [15:0] out_val [256];
  int          out_cyc [256];
  logic [15:0] wr_addr [256];
  logic [15:0] wr_data [256];
  int out_n = 0, wr_n = 0, dev_idx = 0, fall_k = 0;

  assign gen_in = (fall_k >= SETTLE && dev_idx > 0) ? dev_word(dev_idx - 1) : 16'hBAD0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= rd_word(mem_addr);
      if (mem_we) begin
        wr_addr[wr_n[7:0]] <= mem_addr;
        wr_data[wr_n[7:0]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end
    end else mem_ack <= 1'b0;
    if (gen_we) begin
      out_val[out_n[7:0]] <= gen_out;
      out_cyc[out_n[7:0]] <= cyc;
      out_n <= out_n + 1;
    end
    if (gen_we && gen_out[15] && !gen_out[14]) begin
      fall_k  <= 0;
      dev_idx <= dev_idx + 1;
    end else if (fall_k < 100) fall_k <= fall_k + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    summary();
  end

  task automatic launch(input bit d, input logic [15:0] b, input logic [15:0] c);
    @(negedge clk);
    dir_in = d; base = b; count = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R9 done seen", 32'(done), 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 32'(done), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !gen_we && !mem_req, "R1 idle outputs",
        {busy, done, gen_we, mem_req}, 0);
    chk(ptr == 0 && remain == 0, "R1 counters", {ptr, remain}, 0);
  endtask

  task automatic t_zero();
    int o0 = out_n, w0 = wr_n;
    launch(1'b1, 16'h0010, 16'd0);
    wait_done();
    chk(out_n == o0, "R2 no device write", out_n - o0, 0);
    chk(wr_n == w0, "R2 no memory write", wr_n - w0, 0);
    chk(!susp && remain == 0, "R2 state", {susp, remain}, 0);
  endtask

  task automatic t_input();
    int o0 = out_n, w0 = wr_n, d0 = dev_idx;
    launch(1'b1, 16'h0020, 16'd3);
    wait_done();
    chk(out_n - o0 == 6, "R3 write count", out_n - o0, 6);
    for (int i = 0; i < 3; i++) begin
      chk(out_val[o0 + 2*i] == 16'hD000, "R3 clock high word", out_val[o0 + 2*i], 16'hD000);
      chk(out_val[o0 + 2*i + 1] == 16'h9000, "R3 clock low word", out_val[o0 + 2*i + 1], 16'h9000);
      chk(out_cyc[o0 + 2*i + 1] == out_cyc[o0 + 2*i] + 1, "R3 adjacent cycles",
          out_cyc[o0 + 2*i + 1] - out_cyc[o0 + 2*i], 1);
      chk(wr_addr[w0 + i] == 16'h0020 + 16'(i), "R4 store address", wr_addr[w0 + i], 16'h0020 + i);
      chk(wr_data[w0 + i] == dev_word(d0 + i), "R4 settled data", wr_data[w0 + i], dev_word(d0 + i));
    end
    chk(wr_n - w0 == 3, "R4 store count", wr_n - w0, 3);
    chk(ptr == 16'h0023 && remain == 0, "R11 final pointer", {ptr, remain}, {16'h0023, 16'h0});
  endtask

  task automatic check_out_words(input int o0, input logic [15:0] b, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = rd_word(b + 16'(i));
      chk(out_val[o0 + 2*i] == (d | 16'h4000), req, out_val[o0 + 2*i], d | 16'h4000);
      chk(out_val[o0 + 2*i + 1] == (d & ~16'h4000), req, out_val[o0 + 2*i + 1], d & ~16'h4000);
      chk(out_cyc[o0 + 2*i + 1] == out_cyc[o0 + 2*i] + 1, req,
          out_cyc[o0 + 2*i + 1] - out_cyc[o0 + 2*i], 1);
    end
  endtask

  task automatic t_output();
    int o0 = out_n, w0 = wr_n;
    launch(1'b0, 16'h0100, 16'd18);
    wait_done();
    chk(out_n - o0 == 36, "R5 write count", out_n - o0, 36);
    check_out_words(o0, 16'h0100, 18, "R5 output word");
    chk(wr_n == w0, "R5 no memory write", wr_n - w0, 0);
    chk(ptr == 16'h0112 && remain == 0 && !susp, "R11 output end", {ptr, remain}, {16'h0112, 16'h0});
  endtask

  task automatic t_suspend_resume();
    int o0 = out_n, o1;
    irq = 1'b1;
    launch(1'b0, 16'h0200, 16'd20);
    wait_done();
    chk(out_n - o0 == 8, "R6 first group of 4", (out_n - o0) / 2, 4);
    chk(susp, "R7 suspended flag", 32'(susp), 1);
    chk(ptr == 16'h0204 && remain == 16'd16, "R7 resume point", {ptr, remain}, {16'h0204, 16'd16});
    irq = 1'b0;
    o1 = out_n;
    launch(1'b0, ptr, remain);
    wait_done();
    chk(out_n - o1 == 32, "R8 remaining words", (out_n - o1) / 2, 16);
    check_out_words(o1, 16'h0204, 16, "R8 resumed word");
    chk(!susp && ptr == 16'h0214 && remain == 0, "R8 resumed end", {susp, ptr, remain}, {1'b0, 16'h0214, 16'h0});
  endtask

  task automatic t_irq_single_group();
    int o0 = out_n;
    irq = 1'b1;
    launch(1'b0, 16'h0300, 16'd16);
    wait_done();
    irq = 1'b0;
    chk(out_n - o0 == 32, "R6 full single group", (out_n - o0) / 2, 16);
    chk(!susp && remain == 0, "R6 not suspended", {susp, remain}, 0);
  endtask

  task automatic t_ignore_start();
    int o0 = out_n, w0 = wr_n;
    launch(1'b1, 16'h0040, 16'd2);
    repeat (3) @(negedge clk);
    dir_in = 1'b0; base = 16'h0080; count = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(wr_n - w0 == 2, "R10 store count", wr_n - w0, 2);
    chk(wr_addr[w0] == 16'h0040 && wr_addr[w0 + 1] == 16'h0041, "R10 addresses",
        {wr_addr[w0], wr_addr[w0 + 1]}, {16'h0040, 16'h0041});
    chk(out_n - o0 == 4, "R10 direction kept", out_n - o0, 4);
    chk(ptr == 16'h0042 && remain == 0, "R10 count kept", {ptr, remain}, {16'h0042, 16'h0});
    repeat (20) @(negedge clk);
    chk(!busy && out_n - o0 == 4, "R10 no second transfer", out_n - o0, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_input();
    t_output();
    t_suspend_resume();
    t_irq_single_group();
    t_ignore_start();
    summary();
  end
endmodule